// File: doc/BRIEF.md
# SPI Frame Sequencer with Leading Start Bit

This block runs one complete SPI master transfer. A single-cycle `start` pulse, sampled while the block is idle, latches the transfer settings. Chip select is then asserted and the block waits a programmable number of half clock periods. It then produces a burst of serial clock edges that shifts the transmit word out MSB first and assembles the received word. After the last edge it waits the same interval again, deasserts chip select and pulses `done`.

The block does not generate timing of its own. An external divider supplies `edge_stb`, a one-cycle strobe for each half period of the serial clock. Every strobe moves the frame forward by one step: a setup or hold count, a rising edge or a falling edge. Before the data word, the block can send one extra command/data-select bit whose level is fixed by a polarity input. This start bit only lengthens the frame and never enters the received word. An `abort` input ends a transfer at any point.

Top module: `spi_frame_seq`

## Requirements
- R1: The frame has L + S serial clock cycles. S is `sb_en` (0 or 1). L is `word_len` limited to the range 4 to 32: values below 4 give 4 and values above 32 give 32.
- R2: While chip select is active, the first rising edge of `spi_sclk` follows the (2*`cs_delay`+1)-th `edge_stb` pulse that comes after the cycle in which the start was accepted. Codes 0 to 3 therefore give 1, 3, 5 or 7 half periods.
- R3: Chip select deasserts on the (2*`cs_delay`+1)-th `edge_stb` pulse after the last falling edge of `spi_sclk`.
- R4: `spi_sclk` is low while idle. Each bit is stable on `spi_mosi` at its rising edge and changes only after the falling edge. Data bits leave MSB first, starting with bit L-1 of `tx_data`.
- R5: When `sb_en` is 1, the first bit slot drives `spi_mosi` at the level of `sb_pol`. The data bits follow it.
- R6: `miso` is sampled on the rising edges of data bits only, never in the start-bit slot. When `done` is high, `rx_data` holds the L received bits right-aligned (first received bit at position L-1) with all bits above them zero.
- R7: `spi_cs` equals `cs_act_high` while a frame is active and equals its inverse otherwise.
- R8: `done` is high for exactly one cycle, the cycle after chip select deasserts. `busy` is high from the cycle after acceptance until that cycle, and is low while `done` is high.
- R9: When `abort` is high, on the next cycle chip select is inactive, `spi_sclk` is low, `busy` is low, and no `done` pulse follows.
- R10: A `start` pulse while `busy` is high is ignored. All settings are latched at acceptance, so a changed `word_len` or `sb_en` during a frame has no effect and no second frame follows.
- R11: After reset, chip select is inactive, `spi_sclk` and `spi_mosi` are low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a frame (accepted only when idle) |
| abort | input | 1 | Return to idle immediately |
| edge_stb | input | 1 | Half-period strobe from the external divider |
| word_len | input | 6 | Data bits per frame (limited to 4..32) |
| tx_data | input | 32 | Word to transmit, right-aligned |
| sb_en | input | 1 | Send a start bit before the data |
| sb_pol | input | 1 | Level of the start bit |
| cs_delay | input | 2 | Chip-select setup/hold code (2*code+1 half periods) |
| cs_act_high | input | 1 | 1: chip select active high, 0: active low |
| miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip select |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| rx_data | output | 32 | Received word, right-aligned |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench counts strobes between chip-select edges and serial clock edges for every delay code. A setup count off by one, or a hold count that reuses the setup path, shows up as a wrong number of half periods. During the start-bit slot the slave model drives the inverse of the first data bit. A design that samples in that slot shifts garbage into `rx_data` and loses the last bit. Word lengths of 2 and 63 check the limiting, and the 4-bit and 32-bit frames check both ends of the shift path. Other cases cover a start pulse with changed settings in the middle of a frame, and an abort partway through a frame. A design that does not latch its settings, or that lets `done` escape after an abort, fails these.

// File: rtl/spi_frame_seq.sv
`timescale 1ns/1ps
module spi_frame_seq #(
  parameter int MAX_WL = 32,
  parameter int MIN_WL = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          abort,
  input  logic                          edge_stb,
  input  logic [$clog2(MAX_WL+1)-1:0]   word_len,
  input  logic [MAX_WL-1:0]             tx_data,
  input  logic                          sb_en,
  input  logic                          sb_pol,
  input  logic [1:0]                    cs_delay,
  input  logic                          cs_act_high,
  input  logic                          miso,
  output logic                          spi_cs,
  output logic                          spi_sclk,
  output logic                          spi_mosi,
  output logic [MAX_WL-1:0]             rx_data,
  output logic                          busy,
  output logic                          done
);
  localparam int LW = $clog2(MAX_WL+1);
  localparam int BW = $clog2(MAX_WL+2);

  typedef enum logic [1:0] {IDLE, SETUP, SHIFT, HOLD} st_t;

  st_t             st;
  logic [2:0]      hcnt, dly_q;
  logic [BW-1:0]   bit_idx, nbits;
  logic [LW-1:0]   wl_q, wl_clamp;
  logic            sb_q, sbp_q, sclk_q, done_pend, done_q;
  logic [MAX_WL-1:0] tx_sh, rx_sh;
  logic            cs_act, accept, start_slot, rise_now, fall_now, last_fall;

  assign wl_clamp   = (word_len < LW'(MIN_WL)) ? LW'(MIN_WL) :
                      (word_len > LW'(MAX_WL)) ? LW'(MAX_WL) : word_len;
  assign nbits      = BW'(wl_q) + BW'(sb_q);
  assign cs_act     = (st != IDLE);
  assign accept     = start && (st == IDLE) && !done_pend;
  assign start_slot = sb_q && (bit_idx == '0);
  assign rise_now   = edge_stb && (((st == SETUP) && (hcnt == dly_q - 3'd1)) ||
                                   ((st == SHIFT) && !sclk_q));
  assign fall_now   = edge_stb && (st == SHIFT) && sclk_q;
  assign last_fall  = fall_now && (bit_idx == nbits - 1'b1);

  assign spi_cs   = cs_act_high ? cs_act : ~cs_act;
  assign spi_sclk = sclk_q;
  assign spi_mosi = ((st == SETUP) || (st == SHIFT)) ?
                    (start_slot ? sbp_q : tx_sh[MAX_WL-1]) : 1'b0;
  assign rx_data  = rx_sh;
  assign busy     = cs_act | done_pend;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; hcnt <= '0; dly_q <= 3'd1; bit_idx <= '0;
      wl_q <= LW'(MIN_WL); sb_q <= 1'b0; sbp_q <= 1'b0; sclk_q <= 1'b0;
      done_pend <= 1'b0; done_q <= 1'b0; tx_sh <= '0; rx_sh <= '0;
    end else begin
      done_q    <= done_pend;
      done_pend <= 1'b0;
      if (abort) begin
        st     <= IDLE;
        sclk_q <= 1'b0;
      end else begin
        if (rise_now) begin
          sclk_q <= 1'b1;
          if (!start_slot) rx_sh <= {rx_sh[MAX_WL-2:0], miso};
        end
        if (fall_now) begin
          sclk_q  <= 1'b0;
          bit_idx <= bit_idx + 1'b1;
          if (!start_slot) tx_sh <= {tx_sh[MAX_WL-2:0], 1'b0};
        end
        case (st)
          IDLE: if (accept) begin
            st      <= SETUP;
            hcnt    <= '0;
            bit_idx <= '0;
            wl_q    <= wl_clamp;
            sb_q    <= sb_en;
            sbp_q   <= sb_pol;
            dly_q   <= {cs_delay, 1'b1};
            rx_sh   <= '0;
            tx_sh   <= tx_data << (MAX_WL - int'(wl_clamp));
          end
          SETUP: if (edge_stb) begin
            if (rise_now) st <= SHIFT;
            else          hcnt <= hcnt + 3'd1;
          end
          SHIFT: if (last_fall) begin
            st   <= HOLD;
            hcnt <= '0;
          end
          HOLD: if (edge_stb) begin
            if (hcnt == dly_q - 3'd1) begin
              st        <= IDLE;
              done_pend <= 1'b1;
            end else hcnt <= hcnt + 3'd1;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !sclk_q);
  a_r1_bit_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT) |-> (bit_idx < nbits));
  a_r8_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st == IDLE && $past(st) == IDLE && !busy));
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st == IDLE && !sclk_q && !done_pend));
  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != IDLE) |=> ($stable(wl_q) && $stable(sb_q) && $stable(dly_q)));
endmodule

// File: tb/test_spi_frame_seq.sv
`timescale 1ns/1ps
module test_spi_frame_seq;
  logic clk = 0, rst_n = 0, start = 0, abort = 0, edge_stb = 0;
  logic [5:0] word_len = 6'd8;
  logic [31:0] tx_data = '0;
  logic sb_en = 0, sb_pol = 0, cs_act_high = 0, miso = 0;
  logic [1:0] cs_delay = 2'd0;
  logic spi_cs, spi_sclk, spi_mosi, busy, done;
  logic [31:0] rx_data;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_frame_seq i_spi_frame_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .edge_stb(edge_stb),
    .word_len(word_len), .tx_data(tx_data), .sb_en(sb_en), .sb_pol(sb_pol),
    .cs_delay(cs_delay), .cs_act_high(cs_act_high), .miso(miso),
    .spi_cs(spi_cs), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .rx_data(rx_data), .busy(busy), .done(done));

  localparam int NV = 8;
  localparam logic [31:0] V_TX [NV] = '{32'hA5, 32'h5, 32'hDEADBEEF, 32'h1ABC,
                                        32'h3, 32'hFFFFFFFF, 32'h0, 32'h12345};
  localparam logic [31:0] V_RX [NV] = '{32'h3C, 32'hA, 32'h12345678, 32'h0F0F,
                                        32'h2, 32'h80000001, 32'h7F, 32'h54321};
  localparam int V_WL [NV]   = '{8, 4, 32, 13, 2, 63, 7, 20};
  localparam int V_SB [NV]   = '{0, 1, 1, 0, 0, 1, 1, 1};
  localparam int V_SBP [NV]  = '{0, 1, 0, 1, 0, 1, 1, 0};
  localparam int V_CODE [NV] = '{0, 1, 3, 2, 0, 0, 2, 1};
  localparam int V_CSH [NV]  = '{0, 0, 1, 1, 0, 0, 0, 1};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic mbit(input logic [31:0] p, input int ewl, input int sb, input int k);
    int j = k - sb;
    if (sb != 0 && k == 0) return ~p[ewl-1];
    if (j >= ewl) return 1'b0;
    return p[ewl-1-j];
  endfunction

  task automatic run_frame(input logic [31:0] tx, input logic [31:0] rxp, input int wl,
                           input int sb, input int sbp, input int code, input int cshi,
                           input bit inject);
    int ewl = (wl < 4) ? 4 : ((wl > 32) ? 32 : wl);
    int nb = ewl + sb, d = 2 * code + 1;
    int cnt = 0, rises = 0, falls = 0, cyc = 0;
    bit last_sclk = 0, stb_prev = 0, sent_inj = 0;
    logic [63:0] got = '0, m64, expm, expr;
    m64  = (64'd1 << ewl) - 64'd1;
    expm = ({32'd0, tx} & m64) | ((sb != 0) ? (64'(sbp) << ewl) : 64'd0);
    expr = {32'd0, rxp} & m64;
    cs_act_high = cshi[0]; word_len = 6'(wl); tx_data = tx; sb_en = sb[0];
    sb_pol = sbp[0]; cs_delay = 2'(code);
    start = 1; edge_stb = 0; miso = 0;
    @(negedge clk);
    start = 0;
    chk(spi_cs === cshi[0] && busy === 1'b1, "R7 cs active level / R8 busy", {62'd0, spi_cs, busy}, {62'd0, cshi[0], 1'b1});
    miso = mbit(rxp, ewl, sb, 0);
    while (cyc < 4000) begin
      cyc++;
      edge_stb = (cyc % 3 == 0);
      stb_prev = edge_stb;
      if (inject && rises == 2 && !sent_inj) begin
        start = 1; word_len = 6'd9; sb_en = ~sb_en; sent_inj = 1;
      end else start = 0;
      @(negedge clk);
      if (stb_prev) cnt++;
      if (spi_sclk && !last_sclk) begin
        if (rises == 0) chk(cnt == d, "R2 setup half periods", 64'(cnt), 64'(d));
        got = {got[62:0], spi_mosi};
        rises++;
        miso = mbit(rxp, ewl, sb, rises);
      end
      if (!spi_sclk && last_sclk) begin
        falls++;
        if (falls == nb) cnt = 0;
      end
      last_sclk = spi_sclk;
      if (spi_cs !== cshi[0]) break;
    end
    edge_stb = 0; start = 0;
    chk(falls == nb && rises == nb, "R1 bit count", 64'(falls), 64'(nb));
    chk(cnt == d, "R3 hold half periods", 64'(cnt), 64'(d));
    chk(got == expm, "R4/R5 mosi stream", got, expm);
    chk(busy === 1'b1 && done === 1'b0, "R8 busy at cs release", {62'd0, busy, done}, 64'h2);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R8 done after cs release", {62'd0, done, busy}, 64'h2);
    chk({32'd0, rx_data} == expr, "R6 received word", {32'd0, rx_data}, expr);
    @(negedge clk);
    chk(done === 1'b0, "R8 done single cycle", {63'd0, done}, 64'd0);
    if (inject) begin
      repeat (6) @(negedge clk);
      chk(spi_cs === ~cshi[0] && busy === 1'b0, "R10 no frame from busy start", {62'd0, spi_cs, busy}, {62'd0, ~cshi[0], 1'b0});
    end
  endtask

  task automatic run_abort();
    int rises = 0, cyc = 0, seen_done = 0;
    bit last_sclk = 0;
    cs_act_high = 0; word_len = 6'd16; tx_data = 32'hC3C3; sb_en = 1; sb_pol = 1; cs_delay = 2'd1;
    start = 1;
    @(negedge clk);
    start = 0;
    while (rises < 3 && cyc < 1000) begin
      cyc++;
      edge_stb = (cyc % 3 == 0);
      @(negedge clk);
      if (spi_sclk && !last_sclk) rises++;
      last_sclk = spi_sclk;
    end
    edge_stb = 0; abort = 1;
    @(negedge clk);
    abort = 0;
    chk(spi_cs === 1'b1 && spi_sclk === 1'b0 && busy === 1'b0, "R9 abort to idle",
        {61'd0, spi_cs, spi_sclk, busy}, 64'h4);
    for (int i = 0; i < 8; i++) begin
      edge_stb = (i % 3 == 0);
      @(negedge clk);
      if (done === 1'b1) seen_done++;
    end
    edge_stb = 0;
    chk(seen_done == 0, "R9 no done after abort", 64'(seen_done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs === 1'b1 && spi_sclk === 1'b0 && spi_mosi === 1'b0 && busy === 1'b0 && done === 1'b0,
        "R11 reset state", {59'd0, spi_cs, spi_sclk, spi_mosi, busy, done}, 64'h10);
    rst_n = 1;
    @(negedge clk);
    chk(spi_cs === 1'b1 && busy === 1'b0 && done === 1'b0, "R11 after release", {61'd0, spi_cs, busy, done}, 64'h4);
    for (int v = 0; v < NV; v++) begin
      run_frame(V_TX[v], V_RX[v], V_WL[v], V_SB[v], V_SBP[v], V_CODE[v], V_CSH[v], 1'b0);
      repeat (2) @(negedge clk);
    end
    run_frame(32'h96, 32'h69, 8, 0, 0, 1, 0, 1'b1);
    repeat (2) @(negedge clk);
    run_abort();
    repeat (2) @(negedge clk);
    run_frame(32'h1F, 32'h15, 5, 1, 0, 3, 1, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule